// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the strobes and the multiplexed address/data traffic on the external bus of an 8-bit microcontroller core that has no on-chip program store. It runs from the oscillator clock. A machine cycle has six states. Each state lasts two clocks in standard mode and one clock in double-speed mode.

When no data transfer is requested, every machine cycle carries two instruction fetches. Each fetch starts with an address-latch pulse and is followed by a program-store strobe. A data transfer request is taken only at the end of a machine cycle. It then turns the next machine cycle into a data cycle:

- Only the first address-latch pulse is kept.
- Both program-store strobes are dropped.
- A read or write strobe is driven in the middle of the cycle.

The low port carries the low address byte while the latch pulse is high. It then carries data. The high port carries the high address byte, or the core's port-2 latch for a short-address transfer.

The sequencer starts from the end of state 6. The first clock after reset therefore begins state 1 of a fetch cycle. All strobes and port outputs are registered.

Top module: `ext_bus_seq`

## Requirements
- R1: While `rst` is high (synchronous), `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `ad_oe`=0 and `rd_valid`=0. The first clock after reset begins state 1 of a fetch cycle, so `ale` is high after that edge.
- R2: A machine cycle is 12 clocks (2 per state) when `x2_mode`=0 and 6 clocks (1 per state) when `x2_mode`=1. `x2_mode` is sampled only on the last clock of state 6 and applies from the next state 1.
- R3: In a fetch cycle, `ale` is high in states 1 and 4 and `psen_n` is low in states 2, 3, 5 and 6. The address-latch rate is therefore 1/6 of the clock in standard mode and 1/3 in double-speed mode.
- R4: In a fetch cycle, `pc` is sampled on entry to states 1 and 4. In those states `ad_oe`=1 and `ad_out`=`pc[7:0]`. `a_hi`=`pc[15:8]` throughout, and `ad_oe`=0 while `psen_n` is low.
- R5: A transfer is accepted only when `mx_req` is high on the last clock of state 6. `mx_ack` is high in that clock only. A request raised and dropped inside a cycle has no effect, and the next cycle is a fetch.
- R6: A data cycle has `ale` high only in state 1 (the state-4 pulse is dropped) and `psen_n` high in all six states. `ad_out`=`mx_addr[7:0]` with `ad_oe`=1 in state 1. Without a new request, the next cycle is a fetch.
- R7: Data read (`mx_wr`=0): `rd_n` is low in states 3 to 5, `wr_n` stays high, and `ad_oe`=0 in states 2 to 6.
- R8: Data write (`mx_wr`=1): `wr_n` is low in states 3 to 5, `rd_n` stays high, and `ad_oe`=1 with `ad_out`=`mx_wdata` in states 2 to 6.
- R9: In a data cycle, `a_hi`=`mx_addr[15:8]` when `mx_wide`=1. When `mx_wide`=0, `a_hi` is the `p2_latch` value captured at acceptance.
- R10: On the clock edge where `psen_n` or `rd_n` returns high, `ad_in` is captured into `rd_data`. `rd_valid` is high for that one following clock. `rd_code`=1 when the strobe was `psen_n` and 0 when it was `rd_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| x2_mode | input | 1 | 1 selects double-speed (6 clocks per machine cycle) |
| pc | input | 16 | Fetch address from the core |
| mx_req | input | 1 | Data transfer request |
| mx_wr | input | 1 | 1 write, 0 read |
| mx_wide | input | 1 | 1 for 16-bit address, 0 for 8-bit address |
| mx_addr | input | 16 | Data transfer address |
| mx_wdata | input | 8 | Write data byte |
| p2_latch | input | 8 | Port-2 latch contents |
| ad_in | input | 8 | Low port input byte |
| mx_ack | output | 1 | Request accepted this clock |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Low port drive value |
| ad_oe | output | 1 | Low port output enable |
| a_hi | output | 8 | High port drive value |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | One-clock pulse with a new `rd_data` |
| rd_code | output | 1 | Captured byte came from a program fetch |

## Verification
The bench compares every clock of each machine cycle against a model of the strobe pattern. It covers both speeds and switches speed at a cycle boundary. It targets several corner cases:

- **Requests that are not at a boundary.** It raises and drops a request in the middle of a cycle. A sequencer that latched such a request would run a data cycle and drop both program-store strobes.
- **Cycles after a data transfer.** It checks the fetch cycle that follows each transfer. A design that failed to return to fetching would miss the state-4 latch pulse there.
- **Short-address transfers.** It checks the high port on 8-bit-address transfers. A design that drove the address byte would show the wrong high port value.
- **Capture points.** It checks that read data is captured exactly on the strobe's rising edge, including the program-store edge at the end of the cycle before a transfer. A design that sampled one clock late would report the wrong byte or pulse at the wrong time.

A reset in the middle of a run must bring every strobe back to idle.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq (
  input  logic        clk,
  input  logic        rst,
  input  logic        x2_mode,
  input  logic [15:0] pc,
  input  logic        mx_req,
  input  logic        mx_wr,
  input  logic        mx_wide,
  input  logic [15:0] mx_addr,
  input  logic [7:0]  mx_wdata,
  input  logic [7:0]  p2_latch,
  input  logic [7:0]  ad_in,
  output logic        mx_ack,
  output logic        ale,
  output logic        psen_n,
  output logic        rd_n,
  output logic        wr_n,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  output logic [7:0]  a_hi,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        rd_code
);

  logic [2:0]  st, nst;
  logic        ph, x2q, nx2;
  logic        mv, nmv, mw, nmw, m16, nm16;
  logic [15:0] ma, nma, fa, nfa;
  logic [7:0]  wd, nwd, p2q, np2;

  wire tick = x2q | ph;
  wire bnd  = tick && (st == 3'd6);
  assign mx_ack = bnd & mx_req;

  always_comb begin
    nst = st; nx2 = x2q; nmv = mv; nmw = mw; nm16 = m16;
    nma = ma; nfa = fa; nwd = wd; np2 = p2q;
    if (tick) nst = (st == 3'd6) ? 3'd1 : st + 3'd1;
    if (bnd) begin
      nx2 = x2_mode;
      nmv = mx_req;
      if (mx_req) begin
        nmw = mx_wr; nm16 = mx_wide; nma = mx_addr;
        nwd = mx_wdata; np2 = p2_latch;
      end
    end
    if (tick && (nst == 3'd1 || nst == 3'd4)) nfa = pc;
  end

  wire n_alest = (nst == 3'd1) || (nst == 3'd4);
  wire n_strb  = (nst >= 3'd3) && (nst <= 3'd5);
  wire ale_d   = nmv ? (nst == 3'd1) : n_alest;
  wire psen_d  = nmv | n_alest;
  wire rd_d    = !(nmv && !nmw && n_strb);
  wire wr_d    = !(nmv && nmw && n_strb);
  wire oe_d    = ale_d | (nmv && nmw && nst != 3'd1);
  wire [7:0] out_d = ale_d ? (nmv ? nma[7:0] : nfa[7:0]) : nwd;
  wire [7:0] hi_d  = nmv ? (nm16 ? nma[15:8] : np2) : nfa[15:8];
  wire rise = (!psen_n && psen_d) || (!rd_n && rd_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= 3'd6; ph <= 1'b1; x2q <= 1'b0;
      mv <= 1'b0; mw <= 1'b0; m16 <= 1'b0;
      ma <= '0; fa <= '0; wd <= '0; p2q <= '0;
      ale <= 1'b0; psen_n <= 1'b1; rd_n <= 1'b1; wr_n <= 1'b1;
      ad_oe <= 1'b0; ad_out <= '0; a_hi <= '0;
      rd_valid <= 1'b0; rd_data <= '0; rd_code <= 1'b0;
    end else begin
      st <= nst; ph <= ~tick; x2q <= nx2;
      mv <= nmv; mw <= nmw; m16 <= nm16;
      ma <= nma; fa <= nfa; wd <= nwd; p2q <= np2;
      ale <= ale_d; psen_n <= psen_d; rd_n <= rd_d; wr_n <= wr_d;
      ad_oe <= oe_d; ad_out <= out_d; a_hi <= hi_d;
      rd_valid <= rise;
      if (rise) begin
        rd_data <= ad_in;
        rd_code <= !psen_n;
      end
    end
  end

  // R3
  no_code_data_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !psen_n |-> (rd_n && wr_n));

  // R7
  no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // R7
  rd_port_free_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);

  // R8
  wr_port_driven_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> ad_oe);

  // R5
  ack_starts_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    mx_ack |=> (ale && psen_n));

  // R10
  valid_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(!psen_n) && psen_n) || ($past(!rd_n) && rd_n));

  // R6
  ale_not_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> (psen_n && rd_n && wr_n));

endmodule

// File: tb/tb_ext_bus_seq.sv
module tb_ext_bus_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x2_mode = 1'b0, mx_req = 1'b0, mx_wr = 1'b0, mx_wide = 1'b0;
  logic [15:0] pc = '0, mx_addr = '0;
  logic [7:0] mx_wdata = '0, p2_latch = '0, ad_in = '0;
  logic mx_ack, ale, psen_n, rd_n, wr_n, ad_oe, rd_valid, rd_code;
  logic [7:0] ad_out, a_hi, rd_data;

  ext_bus_seq dut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // {x2, req, late, wr, wide, addr[15:0], wdata, p2, adin}
  localparam int NV = 12;
  localparam logic [44:0] VEC [0:NV-1] = '{
    {5'b00000, 16'h1234, 8'h00, 8'h00, 8'hC3},
    {5'b00000, 16'hABCD, 8'h00, 8'h00, 8'h3C},
    {5'b01001, 16'h8F01, 8'h00, 8'h00, 8'h77},
    {5'b01010, 16'h0042, 8'h99, 8'h5E, 8'h12},
    {5'b00000, 16'h2000, 8'h00, 8'h00, 8'h21},
    {5'b10000, 16'h2004, 8'h00, 8'h00, 8'h11},
    {5'b11000, 16'h00F0, 8'h00, 8'hA5, 8'h6E},
    {5'b11011, 16'hC0DE, 8'h3A, 8'h00, 8'h44},
    {5'b11100, 16'h3000, 8'h00, 8'h00, 8'h55},
    {5'b00000, 16'h3002, 8'h00, 8'h00, 8'h66},
    {5'b01100, 16'h4000, 8'h00, 8'h00, 8'h88},
    {5'b00000, 16'h4006, 8'h00, 8'h00, 8'h99}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    bit prev_fetch = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk({ale, psen_n, rd_n, wr_n, ad_oe, rd_valid} == 6'b011100, "R1",
        {ale, psen_n, rd_n, wr_n, ad_oe, rd_valid}, 6'b011100);
    for (int v = 0; v < NV; v++) begin
      logic [44:0] e = VEC[v];
      bit x2 = e[44], rq = e[43], late = e[42], w = e[41], wide = e[40];
      logic [15:0] ad = e[39:24];
      bit f = !(rq && !late), rdc = rq && !late && !w, wrc = rq && !late && w;
      int cps = x2 ? 1 : 2;
      x2_mode = x2; mx_req = rq && !late; mx_wr = w; mx_wide = wide;
      mx_addr = ad; pc = ad; mx_wdata = e[23:16]; p2_latch = e[15:8]; ad_in = e[7:0];
      if (v > 0) begin
        #1;
        // R5 acceptance at boundary
        chk(mx_ack == (rq && !late), "R5", mx_ack, rq && !late);
      end
      rst = 1'b0;
      for (int s = 1; s <= 6; s++) begin
        for (int p = 0; p < cps; p++) begin
          bit ea, ep, er, ew, eo, ev;
          logic [7:0] eout, ehi;
          @(posedge clk); #2;
          if (late && s == 3 && p == 0) mx_req = 1'b1;
          if (late && s == 5 && p == 0) mx_req = 1'b0;
          ea = f ? (s == 1 || s == 4) : (s == 1);
          ep = !(f && !(s == 1 || s == 4));
          er = !(rdc && s >= 3 && s <= 5);
          ew = !(wrc && s >= 3 && s <= 5);
          eo = ea || (wrc && s != 1);
          // R2 R3 R6 R7 R8 strobe pattern per clock
          chk({ale, psen_n, rd_n, wr_n, ad_oe} == {ea, ep, er, ew, eo},
              f ? "R3" : (rdc ? "R7" : "R8"),
              {ale, psen_n, rd_n, wr_n, ad_oe}, {ea, ep, er, ew, eo});
          if (eo) begin
            eout = ea ? ad[7:0] : e[23:16];
            // R4 R6 R8 low port value
            chk(ad_out == eout, f ? "R4" : (ea ? "R6" : "R8"), ad_out, eout);
          end
          ehi = (f || wide) ? ad[15:8] : e[15:8];
          // R4 R9 high port
          chk(a_hi == ehi, f ? "R4" : "R9", a_hi, ehi);
          ev = (p == 0) && ((f && s == 4) || (rdc && s == 6) || (prev_fetch && s == 1));
          // R10 capture pulse
          chk(rd_valid == ev, "R10", rd_valid, ev);
          if (ev) chk({rd_data, rd_code} == {e[7:0], s != 6}, "R10",
                      {rd_data, rd_code}, {e[7:0], s != 6});
        end
      end
      prev_fetch = f;
      @(negedge clk);
    end
    // R1 reset in the middle of a fetch
    mx_req = 1'b0; x2_mode = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #2;
    chk({ale, psen_n, rd_n, wr_n, ad_oe} == 5'b01110, "R1",
        {ale, psen_n, rd_n, wr_n, ad_oe}, 5'b01110);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    chk(ale == 1'b1 && psen_n == 1'b1, "R1", {ale, psen_n}, 2'b11);
    @(posedge clk); #2;
    @(posedge clk); #2;
    // R2 standard mode: state 2 starts on the third clock
    chk(ale == 1'b0 && psen_n == 1'b0, "R2", {ale, psen_n}, 2'b00);
    finish_run();
  end
endmodule